// File: doc/BRIEF.md
# Threshold Window Detector with Consecutive-Fault Filter

This block watches the stream of conversion results from a two-channel light sensor front end. It evaluates only the results that belong to the channel picked by `chan_sel`. Each evaluated result is checked against a programmable window. A low bound and a high bound are each given as a 16-bit word: a 4-bit exponent in bits 15:12 and a 12-bit result in bits 11:0. Results that fall outside the window are counted, with the above-high and below-low runs kept apart. A flag is raised only after a programmed number of consecutive violations, so a single noisy sample cannot raise it.

Two flags come out of the block, one for each side of the window, together with an interrupt request that is the union of the flags. A control bit picks how the flags are held. In latched mode a flag stays set until software reads the status word; this is the mode a register file would load at reset, since its latch bit resets to 1. In transparent mode a flag drops as soon as a result lands back inside the window. The surrounding register file holds the window bounds and resets them to `0x0000` for the low bound and `0xBFFF` for the high bound. The package records both values.

Top module: `thresh_window_detector`

## Requirements
- R1: After reset `flag_hi`, `flag_lo` and `irq` are 0, and both violation runs are empty.
- R2: The value of a bound is its result field (bits 11:0) shifted left by its exponent field (bits 15:12) plus 8. The value of a sample is `smp_mant` shifted left by `smp_exp`. A sample violates high when its value is strictly greater than the high bound's value. It violates low when its value is strictly less than the low bound's value. A sample equal to either bound is in the window.
- R3: `fault_sel` codes 0, 1, 2 and 3 require 1, 2, 4 and 8 consecutive violations. The flag sets at the clock edge that samples the violation completing the run.
- R4: Above-high samples advance only the high run and can set only `flag_hi`. Below-low samples advance only the low run and can set only `flag_lo`.
- R5: An evaluated sample that does not violate a side empties that side's run. This applies both to an in-window sample and to a violation on the opposite side.
- R6: A sample is evaluated only when `smp_valid` is 1 and `smp_ch` equals `chan_sel`. Any other sample changes neither the runs nor the flags.
- R7: With `latch_en` = 1, a set flag holds, including through in-window samples, until a cycle in which `stat_rd` is 1 clears it. A flag set in that same cycle wins over the clear.
- R8: With `latch_en` = 0, a set flag clears at the first evaluated in-window sample, and `stat_rd` has no effect.
- R9: `irq` is 1 exactly when `flag_hi` or `flag_lo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A new conversion result is present this cycle |
| smp_ch | input | 1 | Channel the result belongs to |
| smp_exp | input | 4 | Exponent of the result |
| smp_mant | input | 20 | Mantissa of the result |
| chan_sel | input | 1 | Channel that drives the window logic |
| thr_lo | input | 16 | Low bound, exponent in 15:12, result in 11:0 |
| thr_hi | input | 16 | High bound, exponent in 15:12, result in 11:0 |
| fault_sel | input | 2 | Run length code: 0→1, 1→2, 2→4, 3→8 |
| latch_en | input | 1 | 1 = latched flags, 0 = transparent flags |
| stat_rd | input | 1 | Status word is being read this cycle |
| flag_hi | output | 1 | Above-high run reached the required length |
| flag_lo | output | 1 | Below-low run reached the required length |
| irq | output | 1 | Threshold interrupt request |

## Verification
The assertions check several rules on every cycle. A run grows by exactly one on each counted violation and empties after a non-violating evaluated sample. A completed run always sets its flag in the next cycle. A latched flag holds until a status read. A transparent flag drops on an in-window sample. Samples from the other channel leave the flags alone. The exact comparison arithmetic is shown only by the bench scenarios: ties at each bound, exponent scaling on both the sample and the bound, and the reset bound encodings. The same holds for the run lengths chosen by each fault code, a run broken by an opposite violation, and the priority of a set over a read in the same cycle.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int EXP_W     = 4;
  localparam int MANT_W    = 20;
  localparam int RES_W     = 12;
  localparam int THR_W     = EXP_W + RES_W;
  localparam int FSEL_W    = 2;
  localparam int THR_SHIFT = 8;

  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam int SMP_SPAN = MANT_W + EXP_MAX;
  localparam int THR_SPAN = RES_W + EXP_MAX + THR_SHIFT;
  localparam int CMP_W    = (SMP_SPAN > THR_SPAN) ? SMP_SPAN : THR_SPAN;

  localparam int MAX_RUN = 1 << ((1 << FSEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  localparam logic [THR_W-1:0] THR_LO_RST = '0;
  localparam logic [THR_W-1:0] THR_HI_RST = 16'hBFFF;

  typedef logic [CMP_W-1:0] cmp_t;

  function automatic cmp_t scale_sample(input logic [EXP_W-1:0] e,
                                        input logic [MANT_W-1:0] m);
    cmp_t v;
    v = cmp_t'(m);
    return v << e;
  endfunction

  function automatic cmp_t scale_bound(input logic [THR_W-1:0] t);
    cmp_t v;
    int   sh;
    v  = cmp_t'(t[RES_W-1:0]);
    sh = int'(t[THR_W-1 -: EXP_W]) + THR_SHIFT;
    return v << sh;
  endfunction

  function automatic logic [CNT_W-1:0] run_need(input logic [FSEL_W-1:0] code);
    return CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/wfd_compare.sv
module wfd_compare
  import wfd_pkg::*;
(
  input  logic [EXP_W-1:0]  smp_exp,
  input  logic [MANT_W-1:0] smp_mant,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [THR_W-1:0]  thr_hi,
  output logic              above,
  output logic              below
);
  cmp_t smp_v, lo_v, hi_v;

  always_comb begin
    smp_v = scale_sample(smp_exp, smp_mant);
    lo_v  = scale_bound(thr_lo);
    hi_v  = scale_bound(thr_hi);
    above = smp_v > hi_v;
    below = smp_v < lo_v;
  end

  // R2: with an ordered window a sample can violate only one side
  always_comb begin
    if (lo_v <= hi_v) assert_one_side_R2: assert (!(above && below));
  end
endmodule

// File: rtl/wfd_run_counter.sv
module wfd_run_counter
  import wfd_pkg::*;
#(
  parameter int CAP = MAX_RUN,
  parameter int CW  = CNT_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic          viol,
  input  logic [CW-1:0] need,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [CW-1:0] cnt_inc;

  always_comb begin
    cnt_inc = (cnt < CW'(CAP)) ? cnt + CW'(1) : cnt;
    hit     = eval && viol && (cnt_inc >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (eval) cnt <= viol ? cnt_inc : '0;
  end

  assert_run_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && viol && cnt < CW'(CAP)) |=> cnt == $past(cnt) + CW'(1));

  assert_run_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !viol) |=> cnt == '0);

  assert_run_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(cnt));
endmodule

// File: rtl/wfd_flag_ctrl.sv
module wfd_flag_ctrl #(
  parameter int NFLAG = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic             stat_rd,
  input  logic             eval,
  input  logic             in_win,
  input  logic [NFLAG-1:0] hit,
  output logic [NFLAG-1:0] flag
);
  logic clr;

  always_comb clr = latch_en ? stat_rd : (eval && in_win);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[g] <= 1'b0;
      else if (hit[g]) flag[g] <= 1'b1;
      else if (clr)    flag[g] <= 1'b0;
    end

    assert_set_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag[g]);

    assert_rise_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[g]) |-> $past(hit[g]));

    assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && flag[g] && !stat_rd) |=> flag[g]);

    assert_transparent_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en && eval && in_win) |=> !flag[g]);

    assert_transparent_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en && flag[g] && !(eval && in_win)) |=> flag[g]);
  end
endmodule

// File: rtl/thresh_window_detector.sv
module thresh_window_detector
  import wfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_ch,
  input  logic [EXP_W-1:0]  smp_exp,
  input  logic [MANT_W-1:0] smp_mant,
  input  logic              chan_sel,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [THR_W-1:0]  thr_hi,
  input  logic [FSEL_W-1:0] fault_sel,
  input  logic              latch_en,
  input  logic              stat_rd,
  output logic              flag_hi,
  output logic              flag_lo,
  output logic              irq
);
  localparam int SIDES = 2;   // index 0 = high side, 1 = low side

  logic             above, below, eval, in_win;
  logic [CNT_W-1:0] need;
  logic [SIDES-1:0] viol, hit, flag;
  logic [CNT_W-1:0] run_cnt [SIDES];

  wfd_compare u_cmp (
    .smp_exp (smp_exp),
    .smp_mant(smp_mant),
    .thr_lo  (thr_lo),
    .thr_hi  (thr_hi),
    .above   (above),
    .below   (below)
  );

  always_comb begin
    eval   = smp_valid && (smp_ch == chan_sel);
    in_win = !above && !below;
    need   = run_need(fault_sel);
    viol   = {below, above};
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    wfd_run_counter u_run (
      .clk  (clk),
      .rst_n(rst_n),
      .eval (eval),
      .viol (viol[s]),
      .need (need),
      .cnt  (run_cnt[s]),
      .hit  (hit[s])
    );
  end

  wfd_flag_ctrl #(.NFLAG(SIDES)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_en(latch_en),
    .stat_rd (stat_rd),
    .eval    (eval),
    .in_win  (in_win),
    .hit     (hit),
    .flag    (flag)
  );

  assign flag_hi = flag[0];
  assign flag_lo = flag[1];
  assign irq     = flag_hi | flag_lo;

  assert_other_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ch != chan_sel && !stat_rd) |=> $stable({flag_hi, flag_lo}));

  assert_runs_start_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (run_cnt[0] == '0 && run_cnt[1] == '0));
endmodule

// File: tb/thresh_window_detector_test.sv
module thresh_window_detector_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0, smp_ch = 1'b0, chan_sel = 1'b0;
  logic [3:0]  smp_exp = '0;
  logic [19:0] smp_mant = '0;
  logic [15:0] thr_lo = 16'h0000, thr_hi = 16'hBFFF;
  logic [1:0]  fault_sel = '0;
  logic        latch_en = 1'b1, stat_rd = 1'b0;
  logic        flag_hi, flag_lo, irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    bit    fh;
    bit    fl;
    string tag;
  } item_t;
  item_t sb[$];

  int hc = 0, lc = 0;
  bit mfh = 0, mfl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thresh_window_detector uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ch(smp_ch),
    .smp_exp(smp_exp), .smp_mant(smp_mant), .chan_sel(chan_sel),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .fault_sel(fault_sel),
    .latch_en(latch_en), .stat_rd(stat_rd),
    .flag_hi(flag_hi), .flag_lo(flag_lo), .irq(irq)
  );

  function automatic longint bound_val(input logic [15:0] t);
    return longint'(t[11:0]) * (longint'(1) << (t[15:12] + 8));
  endfunction

  task automatic check(input bit act, input bit exp_v, input string what);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp_v);
    end
  endtask

  // monitor: pops one expected item after each edge that follows a push
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(flag_hi, it.fh, {it.tag, " flag_hi"});
      check(flag_lo, it.fl, {it.tag, " flag_lo"});
      check(irq, it.fh | it.fl, {it.tag, " irq R9"});
    end
  end

  // driver: applies one cycle of stimulus and pushes the model's prediction
  task automatic step(input bit v, input bit ch, input logic [3:0] e,
                      input logic [19:0] m, input bit rd, input string tag);
    longint sv, hv, lv;
    bit ev, ab, be, hit_h, hit_l, clr;
    int need;
    item_t it;
    @(negedge clk);
    smp_valid = v; smp_ch = ch; smp_exp = e; smp_mant = m; stat_rd = rd;
    ev   = v && (ch == chan_sel);
    sv   = longint'(m) * (longint'(1) << e);
    hv   = bound_val(thr_hi);
    lv   = bound_val(thr_lo);
    ab   = ev && (sv > hv);
    be   = ev && (sv < lv);
    need = 1 << fault_sel;
    if (ev) begin
      hc = ab ? ((hc < 8) ? hc + 1 : hc) : 0;
      lc = be ? ((lc < 8) ? lc + 1 : lc) : 0;
    end
    hit_h = ab && (hc >= need);
    hit_l = be && (lc >= need);
    clr   = latch_en ? rd : (ev && !ab && !be);
    mfh   = hit_h | (mfh & !clr);
    mfl   = hit_l | (mfl & !clr);
    it.fh = mfh; it.fl = mfl; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic cfg(input logic [15:0] lo, input logic [15:0] hi,
                     input logic [1:0] fs, input bit lat, input bit sel);
    @(negedge clk);
    thr_lo = lo; thr_hi = hi; fault_sel = fs; latch_en = lat; chan_sel = sel;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flag_hi, 1'b0, "R1 reset flag_hi");
    check(flag_lo, 1'b0, "R1 reset flag_lo");
    check(irq, 1'b0, "R1 reset irq");

    // latched, single-fault, window 4096..65536 on channel 0
    cfg(16'h0010, 16'h0100, 2'd0, 1'b1, 1'b0);
    step(1, 0, 4'd0, 20'd70000, 0, "R2 above high");
    step(1, 0, 4'd0, 20'd30000, 0, "R7 hold through in-window");
    step(0, 0, 4'd0, 20'd0,     1, "R7 status read clears");
    step(1, 0, 4'd0, 20'd65536, 0, "R2 equal to high is inside");
    step(1, 0, 4'd0, 20'd4096,  0, "R2 equal to low is inside");
    step(1, 0, 4'd0, 20'd4095,  0, "R4 below low sets only flag_lo");
    step(1, 0, 4'd1, 20'd32769, 1, "R7 set wins over read");
    step(0, 0, 4'd0, 20'd0,     1, "R7 read clears");
    step(1, 0, 4'd1, 20'd32768, 0, "R2 sample exponent tie");

    // bound exponent scaling: 0x100 << 10 = 262144
    cfg(16'h0010, 16'h2100, 2'd0, 1'b1, 1'b0);
    step(1, 0, 4'd2, 20'd65536, 0, "R2 bound exponent tie");
    step(1, 0, 4'd2, 20'd65537, 0, "R2 bound exponent above");
    step(0, 0, 4'd0, 20'd0,     1, "R7 read clears");

    // four-in-a-row
    cfg(16'h0010, 16'h0100, 2'd2, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1, 0, 4'd0, 20'd70000, 0, "R3 run of four incomplete");
    step(1, 0, 4'd0, 20'd30000, 0, "R5 in-window empties run");
    for (int i = 0; i < 4; i++) step(1, 0, 4'd0, 20'd70000, 0, "R3 run of four");
    step(0, 0, 4'd0, 20'd0, 1, "R7 read clears");

    // eight-in-a-row broken by a low violation
    cfg(16'h0010, 16'h0100, 2'd3, 1'b1, 1'b0);
    for (int i = 0; i < 7; i++) step(1, 0, 4'd0, 20'd70000, 0, "R3 run of eight incomplete");
    step(1, 0, 4'd0, 20'd100, 0, "R5 opposite violation empties run");
    for (int i = 0; i < 8; i++) step(1, 0, 4'd0, 20'd70000, 0, "R3 run of eight");
    step(0, 0, 4'd0, 20'd0, 1, "R7 read clears");

    // two-in-a-row on the low side
    cfg(16'h0010, 16'h0100, 2'd1, 1'b1, 1'b0);
    step(1, 0, 4'd0, 20'd10, 0, "R3 low run of two incomplete");
    step(1, 0, 4'd0, 20'd10, 0, "R4 low run of two");
    step(0, 0, 4'd0, 20'd0,  1, "R7 read clears");

    // channel selection
    cfg(16'h0010, 16'h0100, 2'd0, 1'b1, 1'b0);
    step(1, 1, 4'd0, 20'd70000, 0, "R6 other channel ignored");
    step(1, 1, 4'd0, 20'd10,    0, "R6 other channel ignored");
    cfg(16'h0010, 16'h0100, 2'd0, 1'b1, 1'b1);
    step(1, 0, 4'd0, 20'd70000, 0, "R6 channel 0 ignored when 1 selected");
    step(1, 1, 4'd0, 20'd70000, 0, "R6 selected channel 1 evaluated");
    step(0, 0, 4'd0, 20'd0,     1, "R7 read clears");

    // transparent mode, run of two
    cfg(16'h0010, 16'h0100, 2'd1, 1'b0, 1'b0);
    step(1, 0, 4'd0, 20'd70000, 0, "R8 first of two");
    step(1, 0, 4'd0, 20'd70000, 0, "R8 flag set");
    step(0, 0, 4'd0, 20'd0,     1, "R8 read has no effect");
    step(1, 0, 4'd0, 20'd10,    0, "R8 low violation keeps flag_hi");
    step(1, 0, 4'd0, 20'd30000, 0, "R8 in-window clears");

    // bounds at their reset encodings
    cfg(16'h0000, 16'hBFFF, 2'd0, 1'b1, 1'b0);
    step(1, 0, 4'd0,  20'd0,       0, "R2 zero not below zero bound");
    step(1, 0, 4'd15, 20'hFFFFF,   0, "R2 full-scale sample above 0xBFFF");
    step(0, 0, 4'd0,  20'd0,       1, "R7 read clears");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule